// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block is the register core of a general-purpose I/O controller. Lines are grouped into banks of eight. Each bank owns two 32-bit registers: a data latch and a direction register. Both sit on a simple register bus with address, write enable, write data and read data. The block drives an output value and an output enable for every line. Reading a bank's data register returns the level at the pin for lines set as inputs and the latched value for lines set as outputs. Input pins pass through a two-flop synchronizer before they can be read.

Bank register addresses are not a plain array. Each bank sits at a base computed from its index. Any base that would fall inside the 16-byte interrupt window at 0x90 is moved past that window. The block does not decode the window itself. It hands window accesses to a separate port, so interrupt logic elsewhere can serve them, and it returns that port's read data on the bus. The line count is a parameter. The last bank may be partial.

Top module: `gpio_bank_regfile`

## Requirements
- R1: Out of reset every direction bit is 1, every data latch is 0, `pin_oe` is all zero and `pin_out` is all zero.
- R2: Bank b has its data register at B = 8·(b+1), or at B + 0x10 when B ≥ 0x90. Its direction register sits at that address + 4. Only word-aligned addresses (addr[1:0] = 0) select a bank register. Register bit i maps to line 8·b + i.
- R3: A direction bit of 1 makes the line an input (`pin_oe` low). A direction bit of 0 makes it an output (`pin_oe` high). The new direction takes effect on the clock edge that writes it.
- R4: `pin_out` always carries the data latch, whatever the line's direction. When a line turns to output, it drives the value latched earlier and its `pin_out` does not change in that cycle.
- R5: A data register read returns, per bit, the synchronized pin level for input lines and the latch for output lines. A direction register read returns the direction bits. Bits 31..8 read zero.
- R6: An input pin change applied before rising edge k first appears in read data after edge k+2, when the data register address is held. After edges k and k+1 the read data still shows the old level.
- R7: `bus_rdata` is registered. It shows the register addressed in a cycle after that cycle's rising edge.
- R8: Addresses 0x90–0x9F assert `irq_sel`, present addr[3:0] on `irq_ofs`, pass write data to `irq_wdata`, and assert `irq_we` on writes. Reads there return `irq_rdata`. Writes there leave every bank register unchanged.
- R9: Addresses that map to no register read as zero, and writes to them change nothing.
- R10: The bank count is the line count divided by eight, rounded up. In a partial last bank, bits with no line read zero and ignore writes. With the default of 148 lines the last bank (18) has four lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe for the current address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| pin_in | input | NUM_LINES | Asynchronous pin levels |
| pin_out | output | NUM_LINES | Output value per line (data latch) |
| pin_oe | output | NUM_LINES | Output enable per line (1 = drive) |
| irq_sel | output | 1 | Current address falls in the interrupt window |
| irq_we | output | 1 | Write into the interrupt window |
| irq_ofs | output | 4 | Byte offset inside the interrupt window |
| irq_wdata | output | DATA_W | Write data handed to the interrupt window |
| irq_rdata | input | DATA_W | Read data returned from the interrupt window |

## Verification
A bank decoded at the wrong base shows up at once. A write lands on the wrong slice of `pin_oe` or `pin_out` in the next cycle, and a later read of the intended address returns stale contents. A direction or latch bit that is wrong shows on the pins one cycle after the write. A readback mux that picks the wrong source (pin, latch or interrupt port) shows in `bus_rdata` one cycle after the address is presented. A synchronizer that is too short or too long moves the first cycle of a pin change in read data off the third edge. Unmapped and window writes that leak into a bank show as a change on the pins in the following cycle.

// File: rtl/gpio_rf_pkg.sv
package gpio_rf_pkg;

   localparam int unsigned BANK_STRIDE  = 8;
   localparam int unsigned DIR_OFS      = 4;
   localparam int unsigned IRQ_WIN_BASE = 'h90;
   localparam int unsigned IRQ_WIN_SIZE = 16;
   localparam int unsigned IRQ_OFS_W    = 4;

   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_DATA = 2'd1,
      RGN_DIR  = 2'd2,
      RGN_IRQ  = 2'd3
   } region_e;

   // Base of a bank's register pair; bases landing on the window are moved past it.
   function automatic int unsigned bank_base(int unsigned b);
      int unsigned a;
      a = (b + 1) * BANK_STRIDE;
      if (a >= IRQ_WIN_BASE) a = a + IRQ_WIN_SIZE;
      return a;
   endfunction

   function automatic int unsigned div_ceil(int unsigned n, int unsigned d);
      return (n + d - 1) / d;
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   logic [WIDTH-1:0] stage1_q;
   logic [WIDTH-1:0] stage2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1_q <= '0;
         stage2_q <= '0;
      end else begin
         stage1_q <= async_in;
         stage2_q <= stage1_q;
      end
   end

   assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
   parameter int unsigned LINES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             data_we,
   input  logic             dir_we,
   input  logic [LINES-1:0] wdata,
   input  logic [LINES-1:0] pin_in,
   output logic [LINES-1:0] pin_out,
   output logic [LINES-1:0] pin_oe,
   output logic [LINES-1:0] data_rd,
   output logic [LINES-1:0] dir_rd
);

   logic [LINES-1:0] latch_q;
   logic [LINES-1:0] dir_q;
   logic [LINES-1:0] pin_sync;

   gpio_sync #(.WIDTH(LINES)) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (pin_sync)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '1;
      end else begin
         if (data_we) latch_q <= wdata;
         if (dir_we)  dir_q   <= wdata;
      end
   end

   // Per-line readback source: synchronized pin for inputs, latch for outputs.
   genvar i;
   generate
      for (i = 0; i < LINES; i++) begin : g_line
         assign data_rd[i] = dir_q[i] ? pin_sync[i] : latch_q[i];
      end
   endgenerate

   assign dir_rd  = dir_q;
   assign pin_out = latch_q;
   assign pin_oe  = ~dir_q;

endmodule

// File: rtl/gpio_rf_decode.sv
module gpio_rf_decode
   import gpio_rf_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned NUM_BANKS = 19
) (
   input  logic [ADDR_W-1:0]    addr,
   output logic [NUM_BANKS-1:0] bank_hit,
   output region_e              region,
   output logic [IRQ_OFS_W-1:0] irq_ofs
);

   localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(IRQ_WIN_BASE);
   localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(IRQ_WIN_BASE + IRQ_WIN_SIZE - 1);

   genvar b;
   generate
      for (b = 0; b < NUM_BANKS; b++) begin : g_bank
         localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(bank_base(b));
         assign bank_hit[b] = (addr[ADDR_W-1:3] == BASE_A[ADDR_W-1:3]) &&
                              (addr[1:0] == 2'b00);
      end
   endgenerate

   logic in_window;
   assign in_window = (addr >= WIN_LO) && (addr <= WIN_HI);

   always_comb begin
      if (in_window)       region = RGN_IRQ;
      else if (|bank_hit)  region = addr[2] ? RGN_DIR : RGN_DATA;
      else                 region = RGN_NONE;
   end

   assign irq_ofs = addr[IRQ_OFS_W-1:0];

endmodule

// File: rtl/gpio_bank_regfile.sv
module gpio_bank_regfile
   import gpio_rf_pkg::*;
#(
   parameter int unsigned NUM_LINES      = 148,
   parameter int unsigned LINES_PER_BANK = 8,
   parameter int unsigned ADDR_W         = 8,
   parameter int unsigned DATA_W         = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_we,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [NUM_LINES-1:0] pin_in,
   output logic [NUM_LINES-1:0] pin_out,
   output logic [NUM_LINES-1:0] pin_oe,
   output logic                 irq_sel,
   output logic                 irq_we,
   output logic [3:0]           irq_ofs,
   output logic [DATA_W-1:0]    irq_wdata,
   input  logic [DATA_W-1:0]    irq_rdata
);

   localparam int unsigned NUM_BANKS = div_ceil(NUM_LINES, LINES_PER_BANK);
   localparam int unsigned TOP_ADDR  = bank_base(NUM_BANKS - 1) + DIR_OFS;

   initial begin
      assert (NUM_LINES > 0) else $error("NUM_LINES must be nonzero");
      assert (LINES_PER_BANK <= DATA_W) else $error("bank wider than data bus");
      assert (ADDR_W >= 8) else $error("address too narrow for interrupt window");
      assert (TOP_ADDR < (2 ** ADDR_W)) else $error("banks exceed address space");
   end

   logic [NUM_BANKS-1:0] bank_hit;
   region_e              region;
   logic [IRQ_OFS_W-1:0] ofs;

   gpio_rf_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_BANKS (NUM_BANKS)
   ) i_decode (
      .addr     (bus_addr),
      .bank_hit (bank_hit),
      .region   (region),
      .irq_ofs  (ofs)
   );

   logic [LINES_PER_BANK-1:0] word_data [NUM_BANKS];
   logic [LINES_PER_BANK-1:0] word_dir  [NUM_BANKS];

   genvar b;
   generate
      for (b = 0; b < NUM_BANKS; b++) begin : g_bank
         localparam int unsigned LO    = b * LINES_PER_BANK;
         localparam int unsigned LINES = ((NUM_LINES - LO) < LINES_PER_BANK) ?
                                         (NUM_LINES - LO) : LINES_PER_BANK;
         logic [LINES-1:0] data_rd;
         logic [LINES-1:0] dir_rd;

         gpio_bank #(.LINES(LINES)) i_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .data_we (bus_we && bank_hit[b] && (region == RGN_DATA)),
            .dir_we  (bus_we && bank_hit[b] && (region == RGN_DIR)),
            .wdata   (bus_wdata[LINES-1:0]),
            .pin_in  (pin_in[LO +: LINES]),
            .pin_out (pin_out[LO +: LINES]),
            .pin_oe  (pin_oe[LO +: LINES]),
            .data_rd (data_rd),
            .dir_rd  (dir_rd)
         );

         assign word_data[b] = LINES_PER_BANK'(data_rd);
         assign word_dir[b]  = LINES_PER_BANK'(dir_rd);
      end
   endgenerate

   logic [LINES_PER_BANK-1:0] bank_word;
   logic [DATA_W-1:0]         rd_next;

   always_comb begin
      bank_word = '0;
      for (int k = 0; k < NUM_BANKS; k++) begin
         if (bank_hit[k]) bank_word |= (region == RGN_DIR) ? word_dir[k] : word_data[k];
      end
      unique case (region)
         RGN_IRQ:           rd_next = irq_rdata;
         RGN_DATA, RGN_DIR: rd_next = DATA_W'(bank_word);
         default:           rd_next = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= rd_next;
   end

   assign irq_sel   = (region == RGN_IRQ);
   assign irq_we    = bus_we && irq_sel;
   assign irq_ofs   = ofs;
   assign irq_wdata = bus_wdata;

endmodule

// File: rtl/gpio_bank_regfile_chk.sv
module gpio_bank_regfile_chk
   import gpio_rf_pkg::*;
#(
   parameter int unsigned NUM_LINES      = 148,
   parameter int unsigned LINES_PER_BANK = 8,
   parameter int unsigned ADDR_W         = 8,
   parameter int unsigned DATA_W         = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic                 bus_we,
   input logic [DATA_W-1:0]    bus_wdata,
   input logic [DATA_W-1:0]    bus_rdata,
   input logic [NUM_LINES-1:0] pin_in,
   input logic [NUM_LINES-1:0] pin_out,
   input logic [NUM_LINES-1:0] pin_oe,
   input logic                 irq_sel,
   input logic                 irq_we,
   input logic [3:0]           irq_ofs,
   input logic [DATA_W-1:0]    irq_wdata,
   input logic [DATA_W-1:0]    irq_rdata
);

   localparam logic [ADDR_W-1:0] DIR0_ADDR = ADDR_W'(bank_base(0) + DIR_OFS);

   // R3: the bank 0 direction write shows, inverted, on its output enables
   assert_oe_follows_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == DIR0_ADDR) |=>
      (pin_oe[LINES_PER_BANK-1:0] == ~$past(bus_wdata[LINES_PER_BANK-1:0])));

   // R4: line 0 turning to output keeps its output value steady
   assert_no_glitch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pin_oe[0]) |-> $stable(pin_out[0]));

   // R8: interrupt window reads return the port's data one cycle later
   assert_irq_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_sel |=> (bus_rdata == $past(irq_rdata)));

   // R8: interrupt window writes leave bank registers alone
   assert_irq_write_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && irq_sel) |=> ($stable(pin_out) && $stable(pin_oe)));

   // R9: addresses below the first bank read zero
   assert_low_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[ADDR_W-1:3] == '0) |=> (bus_rdata == '0));

   // R9: writes below the first bank change nothing
   assert_low_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr[ADDR_W-1:3] == '0) |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

bind gpio_bank_regfile gpio_bank_regfile_chk #(
   .NUM_LINES      (NUM_LINES),
   .LINES_PER_BANK (LINES_PER_BANK),
   .ADDR_W         (ADDR_W),
   .DATA_W         (DATA_W)
) i_chk (.*);

// File: tb/test_gpio_bank_regfile.sv
`timescale 1ns/1ps
module test_gpio_bank_regfile;

   localparam int NL = 148;
   localparam int NB = 19;
   localparam int AW = 8;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_we = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [NL-1:0] pin_in = '0;
   logic [NL-1:0] pin_out;
   logic [NL-1:0] pin_oe;
   logic          irq_sel;
   logic          irq_we;
   logic [3:0]    irq_ofs;
   logic [DW-1:0] irq_wdata;
   logic [DW-1:0] irq_rdata = 32'h1234_5678;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_bank_regfile #(.NUM_LINES(NL), .LINES_PER_BANK(8), .ADDR_W(AW), .DATA_W(DW))
   i_gpio_bank_regfile (
      .clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
      .pin_in, .pin_out, .pin_oe, .irq_sel, .irq_we, .irq_ofs, .irq_wdata, .irq_rdata
   );

   function automatic int exp_base(int b);
      int a;
      a = (b + 1) * 8;
      if (a >= 'h90) a = a + 'h10;
      return a;
   endfunction

   function automatic logic [7:0] bank_mask(int b);
      logic [7:0] m;
      m = '0;
      for (int i = 0; i < 8; i++) if (b * 8 + i < NL) m[i] = 1'b1;
      return m;
   endfunction

   function automatic logic [7:0] slice_of(logic [NL-1:0] v, int b);
      logic [7:0] r;
      r = '0;
      for (int i = 0; i < 8; i++) if (b * 8 + i < NL) r[i] = v[b * 8 + i];
      return r;
   endfunction

   task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(int a, logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = '0;
   endtask

   task automatic bus_read(int a, output logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = AW'(a); bus_we = 1'b0;
      @(negedge clk);
      d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [DW-1:0] d;
      check("R1", "pin_oe after reset", DW'(pin_oe[31:0]), '0);
      check("R1", "pin_out after reset", DW'(pin_out[31:0]), '0);
      bus_read(exp_base(0) + 4, d);
      check("R1", "bank0 dir reset", d, 32'hFF);
      bus_read(exp_base(0), d);
      check("R1", "bank0 data reset", d, 32'h00);
      bus_read(exp_base(NB - 1) + 4, d);
      check("R10", "partial bank dir reset", d, 32'h0F);
   endtask

   task automatic t_addr_map();
      logic [DW-1:0] d;
      logic [7:0] p;
      for (int b = 0; b < NB; b++) bus_write(exp_base(b) + 4, DW'((b * 37 + 5) & 'hFF));
      for (int b = 0; b < NB; b++) begin
         p = 8'((b * 37 + 5) & 'hFF) & bank_mask(b);
         bus_read(exp_base(b) + 4, d);
         check("R2", $sformatf("dir readback bank %0d", b), d, DW'(p));
         check("R3", $sformatf("oe bank %0d", b), DW'(slice_of(pin_oe, b)), DW'(~p & bank_mask(b)));
      end
      for (int b = 0; b < NB; b++) bus_write(exp_base(b) + 4, 32'hFF);
      check("R3", "all inputs restored", DW'(pin_oe[31:0]), '0);
   endtask

   task automatic t_no_glitch();
      bus_write(exp_base(1), 32'hA5);
      check("R4", "latch drives while input", DW'(slice_of(pin_out, 1)), 32'hA5);
      check("R3", "still input", DW'(slice_of(pin_oe, 1)), 32'h00);
      @(negedge clk);
      bus_addr = AW'(exp_base(1) + 4); bus_wdata = 32'h00; bus_we = 1'b1;
      @(posedge clk); #1;
      check("R3", "oe on the writing edge", DW'(slice_of(pin_oe, 1)), 32'hFF);
      check("R4", "value on the writing edge", DW'(slice_of(pin_out, 1)), 32'hA5);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic t_mixed_read();
      logic [DW-1:0] d;
      bus_write(exp_base(2) + 4, 32'h0F);
      bus_write(exp_base(2), 32'h3C);
      pin_in[23:16] = 8'h99;
      repeat (4) @(negedge clk);
      bus_read(exp_base(2), d);
      check("R5", "mixed input/output read", d, 32'h39);
      bus_write(exp_base(2), 32'hFFFF_FF3C);
      bus_read(exp_base(2), d);
      check("R5", "upper bits read zero", d, 32'h39);
      check("R4", "bank2 out", DW'(slice_of(pin_out, 2)), 32'h3C);
   endtask

   task automatic t_sync();
      pin_in[7:0] = 8'h00;
      repeat (4) @(negedge clk);
      bus_addr = AW'(exp_base(0));
      bus_we = 1'b0;
      pin_in[7:0] = 8'h81;
      @(negedge clk);
      check("R6", "after 1st edge", bus_rdata, 32'h00);
      @(negedge clk);
      check("R6", "after 2nd edge", bus_rdata, 32'h00);
      @(negedge clk);
      check("R6", "after 3rd edge", bus_rdata, 32'h81);
      check("R7", "registered readback holds", bus_rdata, 32'h81);
   endtask

   task automatic t_irq_window();
      logic [DW-1:0] d;
      logic [NL-1:0] o_before, e_before;
      o_before = pin_out; e_before = pin_oe;
      @(negedge clk);
      bus_addr = 8'h94; bus_wdata = 32'hDEAD_BEEF; bus_we = 1'b1;
      #1;
      check("R8", "irq_sel", DW'(irq_sel), 32'd1);
      check("R8", "irq_we", DW'(irq_we), 32'd1);
      check("R8", "irq_ofs", DW'(irq_ofs), 32'd4);
      check("R8", "irq_wdata", irq_wdata, 32'hDEAD_BEEF);
      @(negedge clk);
      bus_we = 1'b0;
      bus_write('h98, 32'h0000_0000);
      bus_write('h9C, 32'hFFFF_FFFF);
      check("R8", "pins untouched (out)", DW'(pin_out != o_before), 32'd0);
      check("R8", "pins untouched (oe)", DW'(pin_oe != e_before), 32'd0);
      bus_read('h9C, d);
      check("R8", "window read", d, 32'h1234_5678);
      irq_rdata = 32'hCAFE_0001;
      bus_read('h90, d);
      check("R8", "window read 2", d, 32'hCAFE_0001);
   endtask

   task automatic t_unmapped();
      logic [DW-1:0] d;
      logic [NL-1:0] o_before, e_before;
      int addrs [5] = '{'h00, 'h04, 'h09, 'hB0, 'hFC};
      o_before = pin_out; e_before = pin_oe;
      foreach (addrs[i]) bus_write(addrs[i], 32'h0000_0000);
      check("R9", "unmapped writes (out)", DW'(pin_out != o_before), 32'd0);
      check("R9", "unmapped writes (oe)", DW'(pin_oe != e_before), 32'd0);
      foreach (addrs[i]) begin
         bus_read(addrs[i], d);
         check("R9", $sformatf("unmapped read %h", addrs[i]), d, 32'd0);
      end
   endtask

   task automatic t_partial_bank();
      logic [DW-1:0] d;
      bus_write(exp_base(NB - 1), 32'hFF);
      bus_write(exp_base(NB - 1) + 4, 32'h00);
      check("R10", "partial bank out", DW'(pin_out[NL-1:NL-4]), 32'hF);
      check("R10", "partial bank oe", DW'(pin_oe[NL-1:NL-4]), 32'hF);
      bus_read(exp_base(NB - 1), d);
      check("R10", "partial bank data read", d, 32'h0F);
      bus_write(exp_base(NB - 1) + 4, 32'hFF);
      bus_read(exp_base(NB - 1) + 4, d);
      check("R10", "partial bank dir read", d, 32'h0F);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_addr_map();
      t_no_glitch();
      t_mixed_read();
      t_sync();
      t_irq_window();
      t_unmapped();
      t_partial_bank();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule